// File: doc/BRIEF.md
# Parallel converter result bus with byte fold

This block is the result holding and bus presentation stage of a 12-bit parallel-output converter interface. A conversion sequencer hands it each finished result with a single-cycle load strobe. It can also tell the block to hold a fixed marker code instead, after an aborted conversion or while the converter is in its reset phase. Between loads the block keeps the last value. A conversion in progress therefore leaves the previous result readable on the bus until the sequencer loads the new one, which it does as its busy indication drops.

The host side uses an active-low chip select, an active-low read strobe and a byte select. The block drives the data lines only while chip select and read are both asserted. The tri-state is modelled as an output-enable beside the data. A 12-bit host reads the whole word with byte select low. An 8-bit host wired to the upper eight lines reads twice: first with byte select low to get the eight high result bits, then with byte select high, when the four low result bits appear at the top of the bus followed by zeros. The read strobe can either pulse for each access or stay low while only byte select changes.

The output stage is registered. A change on chip select, read or byte select appears on the bus one clock later. A load or marker request appears on the bus two clocks after the strobe is driven, that is, one cycle after the edge that takes it.

Top module: `adc_obus`

## Requirements
- R1: While reset is low the bus enable and the data are low. The held value after reset is the marker 0xFE0, so the first read after reset shows 0xFE0.
- R2: The bus enable is high in a cycle exactly when chip select and read were both low at the previous clock edge. The other three combinations give a low enable.
- R3: Whenever the bus enable is low, all data lines are zero.
- R4: With byte select low at the previous edge, an enabled bus carries the full held word, bit 11 as MSB.
- R5: With byte select high at the previous edge, an enabled bus carries held bits 3..0 on lines 11..8, and lines 7..0 are zero.
- R6: A load strobe copies the result input into the held value at the clock edge. The bus shows the new value from the following cycle, and until then it shows the previous value.
- R7: A marker request sets the held value to 0xFE0, and it takes priority over a load strobe in the same cycle.
- R8: With read held low and only byte select toggled, consecutive cycles alternate between the high-byte view and the folded low-nibble view of the same held value.
- R9: A load during an ongoing read never produces a mixed word. The read shows the entire old word for one more cycle, then the entire new word.
- R10: Without a load strobe or a marker request, the held value does not change, whatever happens on the result input, chip select, read or byte select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | 0: full word view, 1: folded low-nibble view |
| res_load | input | 1 | Single-cycle strobe: take `result` |
| result | input | 12 | Finished conversion result from the sequencer |
| mark_set | input | 1 | Single-cycle strobe: hold the marker code (abort or reset phase) |
| bus_data | output | 12 | Data lines, zero when not driven |
| bus_oe | output | 1 | High when the data lines are driven |

## Verification
The hardest case to reach from the ports is a load that lands in the middle of a read that is already running. The bench must see the old word for exactly one more cycle and then the new one, with no mixture of old and new bits. The bench keeps chip select and read low across each load in a sweep over every 12-bit value, so that each value is first observed as the leftover of the previous load and then as itself. Marker priority is reached by raising both strobes in one cycle with a result that differs from the marker. The hold rule is exercised by changing the result input and the bus controls over many cycles with neither strobe raised.

// File: rtl/adc_obus_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the result bus block.
// Assumes the marker code is defined for the default 12-bit word.
package adc_obus_pkg;
    localparam int unsigned OBUS_DW   = 12;
    localparam int unsigned OBUS_NIB  = 4;
    localparam logic [11:0] OBUS_MARK = 12'hFE0;

    // Presentation format of the bus for one access.
    typedef enum logic {
        FMT_WORD = 1'b0,
        FMT_FOLD = 1'b1
    } obus_fmt_e;
endpackage

// File: rtl/obus_result_latch.sv
`timescale 1ns/1ps
// Module: holds the most recent result or the marker code.
// Assumes load and marker strobes are single-cycle pulses from the sequencer;
// the marker request wins over a simultaneous load.
module obus_result_latch #(
    parameter int unsigned      DW   = 12,
    parameter logic [DW-1:0]    MARK = 12'hFE0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          mark,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] held
);
    // Capture the marker, a new result, or keep the current value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= MARK;
        end else if (mark) begin
            held <= MARK;
        end else if (load) begin
            held <= din;
        end
    end
endmodule

// File: rtl/obus_fold.sv
`timescale 1ns/1ps
// Module: forms the bus word from the held value.
// Full format passes the word through. Fold format puts the low NIB bits on
// the top lines and zeros everywhere else. Assumes NIB < DW.
module obus_fold
    import adc_obus_pkg::*;
#(
    parameter int unsigned DW  = 12,
    parameter int unsigned NIB = 4
) (
    input  obus_fmt_e     fmt,
    input  logic [DW-1:0] held,
    output logic [DW-1:0] word
);
    localparam int unsigned LOW_W = DW - NIB;

    logic [DW-1:0] folded;

    // Wire each bus line of the folded view: top lines from the low nibble.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i >= LOW_W) begin : g_src
            assign folded[i] = held[i - LOW_W];
        end else begin : g_zero
            assign folded[i] = 1'b0;
        end
    end

    // Pick the view requested for this access.
    always_comb begin
        word = (fmt == FMT_FOLD) ? folded : held;
    end
endmodule

// File: rtl/obus_drive.sv
`timescale 1ns/1ps
// Module: registered bus driver with an output enable.
// Assumes select and read are active low. Data is forced to zero while the
// bus is not driven so that nothing stale leaks onto a shared bus model.
module obus_drive #(
    parameter int unsigned DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] data_q,
    output logic          oe_q
);
    logic drive_en;

    // Bus is driven only when both strobes are asserted.
    always_comb begin
        drive_en = !cs_n && !rd_n;
    end

    // Register enable and data together so they change on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            data_q <= '0;
        end else begin
            oe_q   <= drive_en;
            data_q <= drive_en ? word : '0;
        end
    end
endmodule

// File: rtl/adc_obus.sv
`timescale 1ns/1ps
// Module: top of the converter result bus.
// Holds the last result or marker and presents it as a full word or a folded
// low nibble on a registered, enable-qualified bus. Assumes the sequencer
// raises res_load as its busy indication falls, and mark_set on abort/reset.
module adc_obus
    import adc_obus_pkg::*;
#(
    parameter int unsigned   DW   = OBUS_DW,
    parameter int unsigned   NIB  = OBUS_NIB,
    parameter logic [DW-1:0] MARK = OBUS_MARK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          byte_sel,
    input  logic          res_load,
    input  logic [DW-1:0] result,
    input  logic          mark_set,
    output logic [DW-1:0] bus_data,
    output logic          bus_oe
);
    logic [DW-1:0] held_q;
    logic [DW-1:0] view;
    obus_fmt_e     fmt;

    // Decode the byte select into a presentation format.
    always_comb begin
        fmt = byte_sel ? FMT_FOLD : FMT_WORD;
    end

    obus_result_latch #(.DW(DW), .MARK(MARK)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (res_load),
        .mark  (mark_set),
        .din   (result),
        .held  (held_q)
    );

    obus_fold #(.DW(DW), .NIB(NIB)) u_fold (
        .fmt  (fmt),
        .held (held_q),
        .word (view)
    );

    obus_drive #(.DW(DW)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .word   (view),
        .data_q (bus_data),
        .oe_q   (bus_oe)
    );
endmodule

// File: rtl/adc_obus_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the result bus, bound into adc_obus.
module adc_obus_chk #(
    parameter int unsigned   DW   = 12,
    parameter int unsigned   NIB  = 4,
    parameter logic [DW-1:0] MARK = 12'hFE0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          byte_sel,
    input logic          res_load,
    input logic          mark_set,
    input logic [DW-1:0] result,
    input logic [DW-1:0] held_q,
    input logic [DW-1:0] bus_data,
    input logic          bus_oe
);
    // R2: enable follows both strobes of the previous edge.
    p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_oe == ($past(!cs_n) && $past(!rd_n))));

    // R3: undriven bus carries zeros.
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    // R4: full view shows the held word of the previous cycle.
    p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(rst_n) && !$past(byte_sel)) |-> (bus_data == $past(held_q)));

    // R5: folded view has zero low lines and the low nibble on top.
    p_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(rst_n) && $past(byte_sel)) |->
            (bus_data[DW-NIB-1:0] == '0 && bus_data[DW-1:DW-NIB] == $past(held_q[NIB-1:0])));

    // R6: a lone load copies the result.
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !mark_set) |=> (held_q == $past(result)));

    // R7: marker request always yields the marker code.
    p_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mark_set |=> (held_q == MARK));

    // R10: no strobe, no change.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_load && !mark_set) |=> $stable(held_q));
endmodule

bind adc_obus adc_obus_chk #(.DW(DW), .NIB(NIB), .MARK(MARK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .res_load (res_load),
    .mark_set (mark_set),
    .result   (result),
    .held_q   (held_q),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
);

// File: tb/tb_adc_obus.sv
`timescale 1ns/1ps
module tb_adc_obus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        byte_sel = 1'b0;
    logic        res_load = 1'b0;
    logic [11:0] result = '0;
    logic        mark_set = 1'b0;
    logic [11:0] bus_data;
    logic        bus_oe;

    int checks = 0;
    int errors = 0;
    logic [11:0] prev;

    always #2 clk = ~clk;

    adc_obus dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .byte_sel(byte_sel), .res_load(res_load), .result(result),
        .mark_set(mark_set), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    function automatic logic [11:0] fold(input logic [11:0] v);
        return 12'((v & 12'hF) << 8);
    endfunction

    function automatic logic [12:0] expect_bus(input logic c, input logic r,
                                               input logic b, input logic [11:0] v);
        logic en = !c && !r;
        return {en, en ? (b ? fold(v) : v) : 12'h000};
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [12:0] exp);
        checks++;
        if ({bus_oe, bus_data} !== exp) begin
            errors++;
            $display("FAIL %s: oe/data actual %0b/%03h expected %0b/%03h",
                     tag, bus_oe, bus_data, exp[12], exp[11:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with strobes asserted.
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) cyc();
        chk("R1 in reset", 13'h0000);
        rst_n = 1'b1;
        cyc();
        chk("R1 marker after reset", {1'b1, 12'hFE0});
        prev = 12'hFE0;

        // Sweep every value: load during a read, then all strobe combos.
        for (int v = 0; v < 4096; v++) begin
            cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b0;
            result = 12'(v); res_load = 1'b1;
            cyc();
            chk("R9 old word during load", {1'b1, prev});
            res_load = 1'b0;
            result = ~12'(v);
            cyc();
            chk("R6 R9 new word after load", {1'b1, 12'(v)});
            for (int c = 0; c < 8; c++) begin
                cs_n = c[2]; rd_n = c[1]; byte_sel = c[0];
                cyc();
                chk("R2 R3 R4 R5 strobe combo", expect_bus(c[2], c[1], c[0], 12'(v)));
            end
            // R8: read held low, only byte select toggles.
            cs_n = 1'b0; rd_n = 1'b0;
            byte_sel = 1'b0; cyc(); chk("R8 high byte", {1'b1, 12'(v)});
            byte_sel = 1'b1; cyc(); chk("R8 folded nibble", {1'b1, fold(12'(v))});
            prev = 12'(v);
        end

        // R7: marker beats a simultaneous load.
        cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b0;
        result = 12'h123; res_load = 1'b1; mark_set = 1'b1;
        cyc();
        res_load = 1'b0; mark_set = 1'b0;
        cyc();
        chk("R7 marker priority", {1'b1, 12'hFE0});
        byte_sel = 1'b1; cyc();
        chk("R7 R5 marker folded", {1'b1, 12'h000});

        // R7: marker alone after a valid value.
        byte_sel = 1'b0; result = 12'h5A7; res_load = 1'b1; cyc();
        res_load = 1'b0; cyc();
        chk("R6 load before marker", {1'b1, 12'h5A7});
        mark_set = 1'b1; cyc();
        mark_set = 1'b0; cyc();
        chk("R7 marker alone", {1'b1, 12'hFE0});

        // R10: value holds through bus activity and result changes.
        result = 12'hA5C; res_load = 1'b1; cyc();
        res_load = 1'b0;
        for (int i = 0; i < 40; i++) begin
            result = 12'(i * 97);
            cs_n = i[0]; rd_n = i[1]; byte_sel = i[2];
            cyc();
        end
        cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b0; cyc();
        chk("R10 held word", {1'b1, 12'hA5C});
        byte_sel = 1'b1; cyc();
        chk("R10 held nibble", {1'b1, 12'hC00});

        // R1: reset again restores the marker.
        rst_n = 1'b0; cyc();
        chk("R1 second reset", 13'h0000);
        rst_n = 1'b1; byte_sel = 1'b0; cyc();
        chk("R1 marker after second reset", {1'b1, 12'hFE0});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule